// File: doc/BRIEF.md
# Receive Channel Router and Word Interleaver

This block sits between four parallel 16-bit ADC sample streams and a bank of up to four complex downconverter channels. A 32-bit control word chooses, at run time, which ADC feeds each channel's I input and each channel's Q input. A single flag can force every Q input to zero instead.

On the return path, the block takes one complex output sample from each channel when the channels pulse a strobe. It places the samples in a small holding bank. It then sends them as a stream of 16-bit words toward a host link, using a valid/ready handshake. The channel-count field of the control word sets how many words make up one sample set.

The control word is written through a one-cycle write strobe into a pending register. The pending value is copied into the active configuration only while the serializer is idle. Routing and word count therefore never change in the middle of a sample set. A strobe that arrives while a set is still being sent is dropped, and a sticky overrun flag records it.

Top module: `rx_chan_router`

## Requirements
- R1: After reset, outValid and overrun are 0. The active configuration is all zeros, so every routed I and Q output carries ADC 0.
- R2: Channel k's I output equals the ADC selected by the 2-bit field at control bits [5+4k:4+4k]. Field values 0 to 3 select ADC 0 to 3.
- R3: When control bit 3 is 0, channel k's Q output equals the ADC selected by the 2-bit field at control bits [7+4k:6+4k].
- R4: When control bit 3 is 1, every channel's Q output is zero, whatever the Q select fields hold.
- R5: Control bits [2:0] give the channel count. A count of 1, 2 or 4 produces 2, 4 or 8 words per sample set.
- R6: A count of 0, 3, 5, 6 or 7 produces 2 words per sample set, the same as a count of 1.
- R7: Words leave in the order channel 0 I, channel 0 Q, channel 1 I, channel 1 Q, and so on. Each word is the channel sample captured on the accepted strobe.
- R8: A word is consumed only in a cycle where outValid and outReady are both 1. While outReady is 0, outData and outValid hold.
- R9: A chanStrobe that arrives while a set is being sent is ignored: the set in flight is not altered. It also sets overrun, which stays 1 until reset.
- R10: A control word written while a set is being sent has no effect on routing or word count until that set is finished.
- R11: Control bits [31:20] have no effect on routing or word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word |
| adcData | input | 64 | Four ADC samples, ADC n in bits [16n+15:16n] |
| routeI | output | 64 | I input of each channel, channel k in bits [16k+15:16k] |
| routeQ | output | 64 | Q input of each channel, same packing |
| chanI | input | 64 | I output of each channel |
| chanQ | input | 64 | Q output of each channel |
| chanStrobe | input | 1 | Channel outputs valid, start a sample set |
| outData | output | 16 | Serialized word |
| outValid | output | 1 | outData holds a word |
| outReady | input | 1 | Host side takes the word |
| overrun | output | 1 | Sticky flag: a strobe was dropped while busy |

## Verification
A stale or corrupted active configuration shows up on routeI and routeQ in the same cycle, because routing is combinational from the active register. A wrong word counter or last-word limit shows up within one sample set as a set that is too long or too short, or as words out of order on outData. The bench model recomputes routing, queue contents, valid and overrun every cycle, so a divergence is reported on the first clock where it reaches a port. A configuration swap in the middle of a set is caught by holding outReady low during a write and watching the routed outputs.

// File: rtl/rx_route_pkg.sv
package rx_route_pkg;
  localparam int NUM_CH     = 4;
  localparam int NUM_ADC    = 4;
  localparam int SEL_W      = $clog2(NUM_ADC);
  localparam int CNT_W      = 3;
  localparam int CFG_W      = 32;
  localparam int ZQ_BIT     = CNT_W;
  localparam int SEL_BASE   = CNT_W + 1;
  localparam int CFG_USED_W = SEL_BASE + 2 * NUM_CH * SEL_W;
  localparam int MAX_WORDS  = 2 * NUM_CH;
  localparam int IDX_W      = $clog2(MAX_WORDS);

  typedef struct packed {
    logic                           zeroQ;
    logic [NUM_CH-1:0][SEL_W-1:0]   selI;
    logic [NUM_CH-1:0][SEL_W-1:0]   selQ;
  } routeSel_t;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] wordIdx;
  } serStrobe_t;

  function automatic routeSel_t decodeSel(input logic [CFG_USED_W-1:0] w);
    routeSel_t s;
    s.zeroQ = w[ZQ_BIT];
    for (int k = 0; k < NUM_CH; k++) begin
      s.selI[k] = w[SEL_BASE + 2*SEL_W*k +: SEL_W];
      s.selQ[k] = w[SEL_BASE + 2*SEL_W*k + SEL_W +: SEL_W];
    end
    return s;
  endfunction

  function automatic logic [IDX_W-1:0] lastIdxFor(input logic [CNT_W-1:0] c);
    logic [IDX_W-1:0] r;
    case (c)
      3'd2:    r = IDX_W'(3);
      3'd4:    r = IDX_W'(2 * NUM_CH - 1);
      default: r = IDX_W'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rx_route_ctrl.sv
module rx_route_ctrl
  import rx_route_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             chanStrobe,
  input  logic             outReady,
  output routeSel_t        activeSel,
  output serStrobe_t       stb,
  output logic             outValid,
  output logic             overrun
);
  logic [CFG_USED_W-1:0] pendWord;
  logic [CNT_W-1:0]      activeCnt;
  logic                  busy;
  logic [IDX_W-1:0]      wordIdx;
  logic [IDX_W-1:0]      lastIdx;
  logic                  captureNow;
  logic                  advanceNow;
  logic                  unusedCfgBits;

  assign unusedCfgBits = ^cfgWrData[CFG_W-1:CFG_USED_W];
  assign captureNow    = chanStrobe && !busy;
  assign advanceNow    = busy && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendWord <= '0;
    else if (cfgWrEn) pendWord <= cfgWrData[CFG_USED_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= decodeSel('0);
      activeCnt <= '0;
    end else if (!busy) begin
      activeSel <= decodeSel(pendWord);
      activeCnt <= pendWord[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      wordIdx <= '0;
      lastIdx <= '0;
    end else if (captureNow) begin
      busy    <= 1'b1;
      wordIdx <= '0;
      lastIdx <= lastIdxFor(activeCnt);
    end else if (advanceNow) begin
      if (wordIdx == lastIdx) busy <= 1'b0;
      else wordIdx <= wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrun <= 1'b0;
    else if (chanStrobe && busy) overrun <= 1'b1;
  end

  assign outValid = busy;
  assign stb      = '{capture: captureNow, wordIdx: wordIdx};

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> ($stable(activeSel) && $stable(activeCnt))); // R10
  AST_LAST_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (lastIdx == 3'd1 || lastIdx == 3'd3 || lastIdx == 3'd7)); // R5
endmodule

// File: rtl/rx_route_data.sv
module rx_route_data
  import rx_route_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_ADC*SAMPLE_W-1:0] adcData,
  input  routeSel_t                   activeSel,
  input  serStrobe_t                  stb,
  input  logic [NUM_CH*SAMPLE_W-1:0]  chanI,
  input  logic [NUM_CH*SAMPLE_W-1:0]  chanQ,
  output logic [NUM_CH*SAMPLE_W-1:0]  routeI,
  output logic [NUM_CH*SAMPLE_W-1:0]  routeQ,
  output logic [SAMPLE_W-1:0]         outData
);
  logic [SAMPLE_W-1:0] adcArr   [NUM_ADC];
  logic [SAMPLE_W-1:0] holdWord [MAX_WORDS];

  for (genvar a = 0; a < NUM_ADC; a++) begin : g_adc
    assign adcArr[a] = adcData[a*SAMPLE_W +: SAMPLE_W];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_route
    assign routeI[k*SAMPLE_W +: SAMPLE_W] = adcArr[activeSel.selI[k]];
    assign routeQ[k*SAMPLE_W +: SAMPLE_W] =
      activeSel.zeroQ ? '0 : adcArr[activeSel.selQ[k]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < MAX_WORDS; w++) holdWord[w] <= '0;
    end else if (stb.capture) begin
      for (int k = 0; k < NUM_CH; k++) begin
        holdWord[2*k]   <= chanI[k*SAMPLE_W +: SAMPLE_W];
        holdWord[2*k+1] <= chanQ[k*SAMPLE_W +: SAMPLE_W];
      end
    end
  end

  assign outData = holdWord[stb.wordIdx];
endmodule

// File: rtl/rx_chan_router.sv
module rx_chan_router
  import rx_route_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [CFG_W-1:0]            cfgWrData,
  input  logic [NUM_ADC*SAMPLE_W-1:0] adcData,
  output logic [NUM_CH*SAMPLE_W-1:0]  routeI,
  output logic [NUM_CH*SAMPLE_W-1:0]  routeQ,
  input  logic [NUM_CH*SAMPLE_W-1:0]  chanI,
  input  logic [NUM_CH*SAMPLE_W-1:0]  chanQ,
  input  logic                        chanStrobe,
  output logic [SAMPLE_W-1:0]         outData,
  output logic                        outValid,
  input  logic                        outReady,
  output logic                        overrun
);
  routeSel_t  activeSel;
  serStrobe_t stb;

  rx_route_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .chanStrobe (chanStrobe),
    .outReady   (outReady),
    .activeSel  (activeSel),
    .stb        (stb),
    .outValid   (outValid),
    .overrun    (overrun)
  );

  rx_route_data #(.SAMPLE_W(SAMPLE_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .adcData   (adcData),
    .activeSel (activeSel),
    .stb       (stb),
    .chanI     (chanI),
    .chanQ     (chanQ),
    .routeI    (routeI),
    .routeQ    (routeQ),
    .outData   (outData)
  );

  AST_ZERO_Q: assert property (@(posedge clk) disable iff (!rstN)
    activeSel.zeroQ |-> (routeQ == '0)); // R4
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (outData == $past(chanI[SAMPLE_W-1:0]))); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8
endmodule

// File: tb/rx_chan_router_tb.sv
`timescale 1ns/1ps
module rx_chan_router_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [31:0] cfgWrData;
  logic [63:0] adcData;
  logic [63:0] routeI, routeQ, chanI, chanQ;
  logic        chanStrobe;
  logic [15:0] outData;
  logic        outValid;
  logic        outReady;
  logic        overrun;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // pass-through channel stubs
  assign chanI = routeI;
  assign chanQ = routeQ;

  rx_chan_router u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .adcData(adcData), .routeI(routeI), .routeQ(routeQ),
    .chanI(chanI), .chanQ(chanQ), .chanStrobe(chanStrobe),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .overrun(overrun)
  );

  // ---------------- reference model ----------------
  logic [31:0] mPend, mAct;
  bit          mBusy, mOvr;
  logic [15:0] mQ[$];

  function automatic int wordsFor(logic [2:0] c);
    if (c == 3'd2) return 4;
    if (c == 3'd4) return 8;
    return 2;
  endfunction

  function automatic logic [15:0] refRoute(int k, bit isQ, logic [31:0] act, logic [63:0] adc);
    int sel;
    if (isQ && act[3]) return 16'h0;
    sel = int'(act[(isQ ? 6 : 4) + 4*k +: 2]);
    return adc[16*sel +: 16];
  endfunction

  always @(posedge clk) begin
    bit bOld;
    logic [31:0] actOld;
    if (!rstN) begin
      mPend = '0; mAct = '0; mBusy = 0; mOvr = 0; mQ.delete();
    end else begin
      bOld = mBusy;
      actOld = mAct;
      if (mBusy && outReady) begin
        void'(mQ.pop_front());
        if (mQ.size() == 0) mBusy = 0;
      end
      if (chanStrobe && !bOld) begin
        mQ.delete();
        for (int w = 0; w < wordsFor(actOld[2:0]); w++)
          mQ.push_back((w % 2 == 0) ? chanI[16*(w/2) +: 16] : chanQ[16*(w/2) +: 16]);
        mBusy = 1;
      end
      if (chanStrobe && bOld) mOvr = 1;
      if (!bOld) mAct = mPend;
      if (cfgWrEn) mPend = cfgWrData;
    end
  end

  task automatic cmp(bit ok, string tag, logic [63:0] a, logic [63:0] e);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      cmp(outValid == mBusy, "R5 outValid", 64'(outValid), 64'(mBusy));
      if (mBusy && mQ.size() > 0)
        cmp(outData == mQ[0], "R7 outData order", 64'(outData), 64'(mQ[0]));
      cmp(overrun == mOvr, "R9 overrun", 64'(overrun), 64'(mOvr));
      for (int k = 0; k < 4; k++) begin
        logic [15:0] eI, eQ;
        eI = refRoute(k, 0, mAct, adcData);
        eQ = refRoute(k, 1, mAct, adcData);
        cmp(routeI[16*k +: 16] == eI, "R2 routeI", 64'(routeI[16*k +: 16]), 64'(eI));
        cmp(routeQ[16*k +: 16] == eQ, mAct[3] ? "R4 routeQ zero" : "R3 routeQ",
            64'(routeQ[16*k +: 16]), 64'(eQ));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] mkCfg(int cnt, bit zq, int i0, int q0, int i1, int q1,
                                        int i2, int q2, int i3, int q3);
    logic [31:0] w;
    w = '0;
    w[2:0] = 3'(cnt); w[3] = zq;
    w[5:4] = 2'(i0);   w[7:6] = 2'(q0);
    w[9:8] = 2'(i1);   w[11:10] = 2'(q1);
    w[13:12] = 2'(i2); w[15:14] = 2'(q2);
    w[17:16] = 2'(i3); w[19:18] = 2'(q3);
    return w;
  endfunction

  task automatic setAdc(int seed);
    for (int a = 0; a < 4; a++) adcData[16*a +: 16] = 16'(16'h1000 * (a + 1) + seed);
  endtask

  task automatic writeCfg(logic [31:0] w);
    cfgWrEn = 1; cfgWrData = w; tick();
    cfgWrEn = 0; tick(); tick();
  endtask

  task automatic drain(int expWords, string tag);
    int n;
    n = 0;
    outReady = 1;
    repeat (20) begin
      if (outValid) n++;
      tick();
    end
    cmp(n == expWords, tag, 64'(n), 64'(expWords));
  endtask

  task automatic runSet(int expWords, string tag);
    chanStrobe = 1; tick(); chanStrobe = 0;
    drain(expWords, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] held;
    logic [63:0] saved;
    rstN = 0; cfgWrEn = 0; cfgWrData = '0; chanStrobe = 0; outReady = 0;
    setAdc(1);
    repeat (3) tick();
    rstN = 1;
    tick();

    // R1 reset state
    cmp(outValid == 0, "R1 outValid after reset", 64'(outValid), 64'd0);
    cmp(overrun == 0, "R1 overrun after reset", 64'(overrun), 64'd0);
    cmp(routeI == {4{adcData[15:0]}}, "R1 routeI all ADC0", routeI, {4{adcData[15:0]}});
    cmp(routeQ == {4{adcData[15:0]}}, "R1 routeQ all ADC0", routeQ, {4{adcData[15:0]}});

    // R2 / R3 / R5 legal counts
    writeCfg(mkCfg(1, 0, 2, 3, 0, 0, 0, 0, 0, 0));
    cmp(routeI[15:0] == adcData[47:32], "R2 ch0 I from ADC2", 64'(routeI[15:0]), 64'(adcData[47:32]));
    cmp(routeQ[15:0] == adcData[63:48], "R3 ch0 Q from ADC3", 64'(routeQ[15:0]), 64'(adcData[63:48]));
    runSet(2, "R5 one channel gives 2 words");
    setAdc(7);
    writeCfg(mkCfg(2, 0, 1, 0, 3, 2, 0, 0, 0, 0));
    runSet(4, "R5 two channels give 4 words");
    setAdc(19);
    writeCfg(mkCfg(4, 0, 3, 2, 1, 0, 0, 1, 2, 3));
    runSet(8, "R5 four channels give 8 words");

    // R4 zero Q
    writeCfg(mkCfg(4, 1, 0, 3, 1, 3, 2, 3, 3, 3));
    cmp(routeQ == 64'd0, "R4 zero-Q forces Q to zero", routeQ, 64'd0);
    runSet(8, "R4 zero-Q set length");

    // R6 illegal counts
    writeCfg(mkCfg(0, 0, 1, 1, 2, 2, 3, 3, 0, 0));
    runSet(2, "R6 count 0 gives 2 words");
    writeCfg(mkCfg(3, 0, 1, 1, 2, 2, 3, 3, 0, 0));
    runSet(2, "R6 count 3 gives 2 words");
    writeCfg(mkCfg(7, 0, 1, 1, 2, 2, 3, 3, 0, 0));
    runSet(2, "R6 count 7 gives 2 words");

    // R8 hold under back-pressure
    writeCfg(mkCfg(4, 0, 0, 1, 2, 3, 1, 0, 3, 2));
    outReady = 0;
    chanStrobe = 1; tick(); chanStrobe = 0;
    held = outData;
    repeat (3) begin
      tick();
      cmp(outValid == 1, "R8 valid held while not ready", 64'(outValid), 64'd1);
      cmp(outData == held, "R8 data held while not ready", 64'(outData), 64'(held));
    end
    drain(8, "R8 full set after stall");

    // R9 strobe while busy
    writeCfg(mkCfg(2, 0, 1, 2, 3, 0, 0, 0, 0, 0));
    outReady = 0;
    chanStrobe = 1; tick();
    setAdc(77); tick(); chanStrobe = 0;
    cmp(overrun == 1, "R9 overrun set by busy strobe", 64'(overrun), 64'd1);
    drain(4, "R9 set in flight unchanged in length");
    cmp(overrun == 1, "R9 overrun sticky", 64'(overrun), 64'd1);

    // R10 config held while busy
    writeCfg(mkCfg(1, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    outReady = 0;
    chanStrobe = 1; tick(); chanStrobe = 0;
    cfgWrEn = 1; cfgWrData = mkCfg(4, 0, 3, 0, 0, 0, 0, 0, 0, 0); tick(); cfgWrEn = 0;
    repeat (3) tick();
    cmp(routeI[15:0] == adcData[31:16], "R10 route unchanged while busy",
        64'(routeI[15:0]), 64'(adcData[31:16]));
    drain(2, "R10 word count unchanged while busy");
    cmp(routeI[15:0] == adcData[63:48], "R10 new route after set",
        64'(routeI[15:0]), 64'(adcData[63:48]));

    // R11 upper bits ignored
    writeCfg(mkCfg(2, 0, 2, 1, 3, 0, 0, 0, 0, 0));
    saved = routeI;
    writeCfg(mkCfg(2, 0, 2, 1, 3, 0, 0, 0, 0, 0) | 32'hFFF0_0000);
    cmp(routeI == saved, "R11 upper bits leave routing", routeI, saved);
    runSet(4, "R11 upper bits leave word count");

    // mixed traffic, checked by the model every cycle
    for (int i = 0; i < 300; i++) begin
      outReady = (i % 3) != 2;
      chanStrobe = (i % 7) == 0;
      setAdc(i * 13);
      if (i % 60 == 30) begin
        cfgWrEn = 1;
        cfgWrData = mkCfg((i / 60) % 8, (i / 60) % 2 == 1, i % 4, (i + 1) % 4, (i + 2) % 4,
                          (i + 3) % 4, (i / 4) % 4, (i / 8) % 4, (i / 16) % 4, (i / 32) % 4);
      end
      tick();
      cfgWrEn = 0;
    end
    chanStrobe = 0;
    outReady = 1;
    repeat (20) tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule